// File: doc/BRIEF.md
# Display Controller Register and Interrupt Unit

This block is the register file of a display controller. A simple 32-bit register bus writes and reads a set of word registers: five display control words, three frame-buffer start address words, a dither setting, and four small interrupt and selection registers. Each register keeps only the bits of its own write width.

The unit decodes the control words into signals for the display engine. These are the display enable, the pixel depth code, the palette colour format, the byte ordering, and the active line width and frame height. The display engine pulses `frameDone` once per finished frame. That pulse sets a frame-sync source bit. Source bits that are not masked are latched into a sticky pending register, and any set pending bit drives a single level interrupt line.

Top module: `lcd_regfile`

## Requirements
- R1: After reset, every register reads as zero. `irq`, `dispEnable`, `bppCode`, `palette565` and `msbFirst` are low, and the width and height outputs are 1.
- R2: Byte offsets: control words 0x00/0x04/0x08/0x0C/0x10, start addresses 0x14/0x18/0x1C, dither 0x4C, pending 0x54, source 0x58, mask 0x5C, selection 0x60. A read presents its data and `busRdErr`=0 on `busRdData` in the cycle after `busRdEn`. `busRdData` is zero in cycles with no read.
- R3: Writes keep bits [17:0] of control word 0, bits [15:0] of control word 3 and bits [12:0] of control word 4. Control words 1 and 2, the start addresses and the dither word keep all 32 bits.
- R4: `dispEnable` is bit 0 of control word 0, and `bppCode` is its bits [4:1].
- R5: `palette565` is bit 11 of control word 4, and `msbFirst` is its bit 12.
- R6: `activeHeight` is control word 1 bits [23:14] plus one (11 bits). `activeWidth` is control word 2 bits [18:8] plus one (12 bits).
- R7: Writes to pending and source keep bits [1:0], and writes to the mask keep bits [2:0]. A write to the selection register stores bits [1:0] and sets bit 2 to one.
- R8: At every clock edge, pending becomes (the written value if pending is written this cycle, else its old value) ORed with (new source AND NOT new mask[1:0]). "New" means after this cycle's writes and frame pulse.
- R9: `irq` is high exactly while the pending register is nonzero.
- R10: A `frameDone` pulse sets source bit 1 at the same edge. If a source write happens in the same cycle, bit 1 is still set.
- R11: A read of an unmapped offset returns zero and raises `busRdErr` for exactly one cycle. A write to an unmapped offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, one cycle after the strobe |
| busRdErr | output | 1 | One-cycle flag for an unmapped read |
| frameDone | input | 1 | End-of-frame pulse from the display engine |
| irq | output | 1 | Level interrupt |
| dispEnable | output | 1 | Display enable |
| bppCode | output | 4 | Pixel depth code |
| palette565 | output | 1 | Palette colour format select |
| msbFirst | output | 1 | Byte ordering select |
| activeWidth | output | 12 | Active pixels per line |
| activeHeight | output | 11 | Active lines per frame |

## Verification
The bench targets the ordering inside one cycle in the interrupt path. Cases include unmasking a source whose bit is already set, clearing pending while a source is still unmasked, and a frame pulse arriving under a full mask. A design that sampled the old source or mask would raise the interrupt a cycle late or lose a frame event. A design that let a pending write win over the source term would drop the interrupt while its source is still active.

Write widths are checked with all-ones patterns, and the selection register with a zero write. A wrong width or a missing forced bit shows up in read-back. Unmapped reads and writes are mixed into a seeded random stream, so an aliasing decode would corrupt shadowed registers.

// File: rtl/lcd_regfile_pkg.sv
package lcd_regfile_pkg;

  localparam int LCD_DW    = 32;
  localparam int NUM_REGS  = 13;
  localparam int IDX_W     = $clog2(NUM_REGS);
  localparam int NUM_PLAIN = 9;   // indices below this are plain masked words

  // register indices
  localparam int RI_CTL0 = 0;
  localparam int RI_CTL1 = 1;
  localparam int RI_CTL2 = 2;
  localparam int RI_CTL3 = 3;
  localparam int RI_CTL4 = 4;
  localparam int RI_ADR0 = 5;
  localparam int RI_ADR1 = 6;
  localparam int RI_ADR2 = 7;
  localparam int RI_DITH = 8;
  localparam int RI_PND  = 9;
  localparam int RI_SRC  = 10;
  localparam int RI_MSK  = 11;
  localparam int RI_SEL  = 12;

  // field geometry
  localparam int EN_BIT     = 0;
  localparam int BPP_LSB    = 1;
  localparam int BPP_W      = 4;
  localparam int FMT_BIT    = 11;
  localparam int ORD_BIT    = 12;
  localparam int HGT_LSB    = 14;
  localparam int HGT_FW     = 10;
  localparam int WID_LSB    = 8;
  localparam int WID_FW     = 11;
  localparam int HGT_W      = HGT_FW + 1;
  localparam int WID_W      = WID_FW + 1;
  localparam int INT_W      = 2;
  localparam int MSK_W      = 3;
  localparam int SEL_W      = 2;
  localparam int FSYNC_BIT  = 1;

  function automatic logic [11:0] regOffset(input int idx);
    case (idx)
      RI_CTL0: return 12'h000;
      RI_CTL1: return 12'h004;
      RI_CTL2: return 12'h008;
      RI_CTL3: return 12'h00C;
      RI_CTL4: return 12'h010;
      RI_ADR0: return 12'h014;
      RI_ADR1: return 12'h018;
      RI_ADR2: return 12'h01C;
      RI_DITH: return 12'h04C;
      RI_PND:  return 12'h054;
      RI_SRC:  return 12'h058;
      RI_MSK:  return 12'h05C;
      default: return 12'h060;
    endcase
  endfunction

  function automatic logic [LCD_DW-1:0] regWrMask(input int idx);
    case (idx)
      RI_CTL0: return LCD_DW'((64'd1 << 18) - 1);
      RI_CTL3: return LCD_DW'((64'd1 << 16) - 1);
      RI_CTL4: return LCD_DW'((64'd1 << 13) - 1);
      default: return '1;
    endcase
  endfunction

  typedef struct packed {
    logic [NUM_REGS-1:0] wrHot;
    logic                rdFire;
    logic                rdMiss;
    logic [IDX_W-1:0]    rdIdx;
  } lcd_strobe_t;

endpackage

// File: rtl/lcd_regfile_ctrl.sv
module lcd_regfile_ctrl
  import lcd_regfile_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output lcd_strobe_t       strobe
);

  logic [NUM_REGS-1:0] hit;
  logic [IDX_W-1:0]    hitIdx;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    localparam logic [11:0] OFS = regOffset(i);
    assign hit[i] = (busAddr == ADDR_W'(OFS));
  end

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (hit[i]) hitIdx = IDX_W'(i);
    end
  end

  always_comb begin
    strobe.wrHot  = hit & {NUM_REGS{busWrEn}};
    strobe.rdFire = busRdEn & (|hit);
    strobe.rdMiss = busRdEn & ~(|hit);
    strobe.rdIdx  = hitIdx;
  end

endmodule

// File: rtl/lcd_regfile_dp.sv
module lcd_regfile_dp
  import lcd_regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  lcd_strobe_t       strobe,
  input  logic [LCD_DW-1:0] busWrData,
  input  logic              frameDone,
  output logic [LCD_DW-1:0] busRdData,
  output logic              busRdErr,
  output logic              irq,
  output logic              dispEnable,
  output logic [BPP_W-1:0]  bppCode,
  output logic              palette565,
  output logic              msbFirst,
  output logic [WID_W-1:0]  activeWidth,
  output logic [HGT_W-1:0]  activeHeight
);

  logic [NUM_PLAIN-1:0][LCD_DW-1:0] plainVal;
  logic [NUM_REGS-1:0][LCD_DW-1:0]  readVal;

  // plain masked word registers
  for (genvar i = 0; i < NUM_PLAIN; i++) begin : g_plain
    localparam logic [LCD_DW-1:0] WMASK = regWrMask(i);
    logic [LCD_DW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN)                 q <= '0;
      else if (strobe.wrHot[i])  q <= busWrData & WMASK;
    end
    assign plainVal[i] = q;
    assign readVal[i]  = q;
  end

  // interrupt and selection registers
  logic [INT_W-1:0] pndQ, srcQ, pndN, srcN;
  logic [MSK_W-1:0] mskQ, mskN;
  logic [SEL_W:0]   selQ;

  always_comb begin
    srcN = strobe.wrHot[RI_SRC] ? busWrData[INT_W-1:0] : srcQ;
    if (frameDone) srcN[FSYNC_BIT] = 1'b1;
    mskN = strobe.wrHot[RI_MSK] ? busWrData[MSK_W-1:0] : mskQ;
    pndN = (strobe.wrHot[RI_PND] ? busWrData[INT_W-1:0] : pndQ)
         | (srcN & ~mskN[INT_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pndQ <= '0;
      srcQ <= '0;
      mskQ <= '0;
      selQ <= '0;
    end else begin
      pndQ <= pndN;
      srcQ <= srcN;
      mskQ <= mskN;
      if (strobe.wrHot[RI_SEL]) selQ <= {1'b1, busWrData[SEL_W-1:0]};
    end
  end

  assign readVal[RI_PND] = LCD_DW'(pndQ);
  assign readVal[RI_SRC] = LCD_DW'(srcQ);
  assign readVal[RI_MSK] = LCD_DW'(mskQ);
  assign readVal[RI_SEL] = LCD_DW'(selQ);

  assign irq = |pndQ;

  // read return path
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdData <= '0;
      busRdErr  <= 1'b0;
    end else begin
      busRdErr <= strobe.rdMiss;
      if (strobe.rdFire && (int'(strobe.rdIdx) < NUM_REGS))
        busRdData <= readVal[strobe.rdIdx];
      else
        busRdData <= '0;
    end
  end

  // decoded configuration
  assign dispEnable   = plainVal[RI_CTL0][EN_BIT];
  assign bppCode      = plainVal[RI_CTL0][BPP_LSB +: BPP_W];
  assign palette565   = plainVal[RI_CTL4][FMT_BIT];
  assign msbFirst     = plainVal[RI_CTL4][ORD_BIT];
  assign activeHeight = HGT_W'(plainVal[RI_CTL1][HGT_LSB +: HGT_FW]) + HGT_W'(1);
  assign activeWidth  = WID_W'(plainVal[RI_CTL2][WID_LSB +: WID_FW]) + WID_W'(1);

  // R10
  frame_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(frameDone) |-> srcQ[FSYNC_BIT]);

  // R8
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !strobe.wrHot[RI_PND]) |=> irq);

  // R7
  sel_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.wrHot[RI_SEL]) |-> selQ[SEL_W]);

  // R11
  rd_err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRdErr |-> ($past(strobe.rdMiss) && busRdData == '0));

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.wrHot[RI_CTL0]) |-> ($stable(dispEnable) && $stable(bppCode)));

endmodule

// File: rtl/lcd_regfile.sv
module lcd_regfile
  import lcd_regfile_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              busRdErr,
  input  logic              frameDone,
  output logic              irq,
  output logic              dispEnable,
  output logic [3:0]        bppCode,
  output logic              palette565,
  output logic              msbFirst,
  output logic [11:0]       activeWidth,
  output logic [10:0]       activeHeight
);

  lcd_strobe_t strobe;

  lcd_regfile_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  lcd_regfile_dp dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .busWrData    (busWrData),
    .frameDone    (frameDone),
    .busRdData    (busRdData),
    .busRdErr     (busRdErr),
    .irq          (irq),
    .dispEnable   (dispEnable),
    .bppCode      (bppCode),
    .palette565   (palette565),
    .msbFirst     (msbFirst),
    .activeWidth  (activeWidth),
    .activeHeight (activeHeight)
  );

endmodule

// File: tb/lcd_regfile_tb_top.sv
module lcd_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        busRdErr;
  logic        frameDone = 1'b0;
  logic        irq;
  logic        dispEnable;
  logic [3:0]  bppCode;
  logic        palette565;
  logic        msbFirst;
  logic [11:0] activeWidth;
  logic [10:0] activeHeight;

  int testCnt = 0;
  int failCnt = 0;

  always #4 clk = ~clk;   // 125 MHz

  lcd_regfile #(.ADDR_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .busRdErr(busRdErr), .frameDone(frameDone), .irq(irq),
    .dispEnable(dispEnable), .bppCode(bppCode), .palette565(palette565),
    .msbFirst(msbFirst), .activeWidth(activeWidth), .activeHeight(activeHeight)
  );

  // shadow model, indexed by slot
  logic [31:0] mdl [13];

  function automatic logic [7:0] slotAddr(input int s);
    logic [7:0] t [13] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18,
                           8'h1C, 8'h4C, 8'h54, 8'h58, 8'h5C, 8'h60};
    return t[s];
  endfunction

  function automatic logic [31:0] slotKeep(input int s);
    case (s)
      0: return 32'h0003_FFFF;
      3: return 32'h0000_FFFF;
      4: return 32'h0000_1FFF;
      9, 10: return 32'h3;
      11: return 32'h7;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [7:0] badAddr(input int k);
    logic [7:0] t [6] = '{8'h20, 8'h64, 8'h02, 8'hFC, 8'h50, 8'h11};
    return t[k];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mdlSettle();
    mdl[9] = mdl[9] | (mdl[10] & ~mdl[11] & 32'h3);
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(posedge clk); #1;
    @(negedge clk);
    busWrEn = 1'b0;
    for (int s = 0; s < 13; s++) begin
      if (slotAddr(s) == a) begin
        if (s == 12) mdl[s] = {29'd0, 1'b1, d[1:0]};
        else         mdl[s] = d & slotKeep(s);
      end
    end
    mdlSettle();
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d, output logic e);
    busRdEn = 1'b1; busAddr = a;
    @(posedge clk); #1;
    d = busRdData; e = busRdErr;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic pulseFrame();
    frameDone = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    frameDone = 1'b0;
    mdl[10] = mdl[10] | 32'h2;
    mdlSettle();
  endtask

  task automatic readSlot(input int s, input string req);
    logic [31:0] d; logic e;
    busRead(slotAddr(s), d, e);
    check(req, d, mdl[s]);
    check(req, 32'(e), 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic e;
    for (int s = 0; s < 13; s++) mdl[s] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 enable", 32'(dispEnable), 0);
    check("R1 bpp", 32'(bppCode), 0);
    check("R1 fmt", 32'({palette565, msbFirst}), 0);
    check("R1 width", 32'(activeWidth), 1);
    check("R1 height", 32'(activeHeight), 1);
    for (int s = 0; s < 13; s++) readSlot(s, "R1 R2 reset readback");
    check("R2 idle rdata", busRdData, 0);

    // R3 / R4 control word 0
    busWrite(8'h00, 32'hFFFF_FFFF);
    readSlot(0, "R3 ctl0 width");
    check("R4 enable", 32'(dispEnable), 1);
    check("R4 bpp", 32'(bppCode), 32'hF);
    busWrite(8'h00, 32'h0000_000C);
    check("R4 enable off", 32'(dispEnable), 0);
    check("R4 bpp 6", 32'(bppCode), 6);

    // R3 / R5
    busWrite(8'h0C, 32'hFFFF_FFFF); readSlot(3, "R3 ctl3 width");
    busWrite(8'h10, 32'hFFFF_FFFF); readSlot(4, "R3 ctl4 width");
    check("R5 both", 32'({palette565, msbFirst}), 32'h3);
    busWrite(8'h10, 32'h0000_0800);
    check("R5 fmt only", 32'({palette565, msbFirst}), 32'h2);
    busWrite(8'h10, 32'h0000_1000);
    check("R5 order only", 32'({palette565, msbFirst}), 32'h1);

    // R6 geometry
    busWrite(8'h04, 32'hFFFF_FFFF); readSlot(1, "R3 ctl1 full");
    check("R6 height max", 32'(activeHeight), 1024);
    busWrite(8'h08, 32'hFFFF_FFFF); readSlot(2, "R3 ctl2 full");
    check("R6 width max", 32'(activeWidth), 2048);
    busWrite(8'h04, 32'h0000_C000);
    check("R6 height 4", 32'(activeHeight), 4);
    busWrite(8'h08, 32'h0000_0500);
    check("R6 width 6", 32'(activeWidth), 6);

    // R7 selection and small registers
    busWrite(8'h60, 32'h0);          readSlot(12, "R7 sel forced");
    busWrite(8'h60, 32'hFFFF_FFFF);  readSlot(12, "R7 sel full");
    busWrite(8'h5C, 32'hFFFF_FFFF);  readSlot(11, "R7 mask width");
    busWrite(8'h58, 32'hFFFF_FFFF);  readSlot(10, "R7 src width");
    readSlot(9, "R8 masked src no pend");
    check("R9 irq low masked", 32'(irq), 0);

    // R8 unmask an already-set source
    busWrite(8'h5C, 32'h1);
    check("R8 unmask same edge", 32'(irq), 1);
    readSlot(9, "R8 pend after unmask");
    busWrite(8'h54, 32'h0);
    readSlot(9, "R8 pend write loses to source");
    busWrite(8'h58, 32'h0);
    busWrite(8'h54, 32'h0);
    check("R9 irq cleared", 32'(irq), 0);
    readSlot(9, "R9 pend zero");

    // R10 frame sync
    busWrite(8'h5C, 32'h0);
    pulseFrame();
    check("R10 irq from frame", 32'(irq), 1);
    readSlot(10, "R10 src bit1");
    busWrite(8'h5C, 32'h7);
    busWrite(8'h58, 32'h0);
    busWrite(8'h54, 32'h0);
    pulseFrame();
    check("R10 masked frame irq", 32'(irq), 0);
    readSlot(10, "R10 src set under mask");

    // R10 frame pulse with a source write in the same cycle
    frameDone = 1'b1;
    busWrite(8'h58, 32'h0);
    frameDone = 1'b0;
    mdl[10] = mdl[10] | 32'h2; mdlSettle();
    readSlot(10, "R10 pulse beats write");

    // R11 unmapped
    for (int k = 0; k < 6; k++) begin
      busRead(badAddr(k), d, e);
      check("R11 unmapped data", d, 0);
      check("R11 unmapped err", 32'(e), 1);
      @(posedge clk); #1;
      check("R11 err one cycle", 32'(busRdErr), 0);
      @(negedge clk);
    end

    // random mix, fixed seed
    void'($urandom(32'h5EED_1234));
    for (int n = 0; n < 400; n++) begin
      int op;
      int s;
      op = int'($urandom_range(0, 9));
      s  = int'($urandom_range(0, 12));
      if (op < 4) begin
        busWrite(slotAddr(s), $urandom());
      end else if (op == 4) begin
        busWrite(badAddr(int'($urandom_range(0, 5))), $urandom());
      end else if (op == 5) begin
        pulseFrame();
      end else begin
        readSlot(s, "R2 R3 R7 R8 R11 random readback");
      end
      check("R9 irq vs pending", 32'(irq), 32'(mdl[9] != 0));
      check("R4 random enable", 32'(dispEnable), 32'(mdl[0][0]));
      check("R6 random width", 32'(activeWidth), 32'(mdl[2][18:8]) + 1);
    end

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule